// File: doc/BRIEF.md
# Distributed Bus Arbitration Node

One instance of this block sits in each device on a synchronous shared bus that has no central arbiter. Every device drives its own request line. Every device also watches the full set of request lines and decides on its own whether it owns the bus in the next cycle. All nodes see the same lines and apply the same rule, so they all reach the same decision. Each node therefore also keeps a small record of who held the bus in the current and the previous cycle, and that record matches in every node. A bus transaction lasts one clock cycle.

The node is a clocked Moore machine, so its outputs come straight from its state register. A local transfer request is taken in and turned into a request on the bus line. That request is held until the node wins a cycle. The node then asserts its master output for exactly one cycle, and after that spends one cycle in backoff. During backoff the node may still drive its request line, but that line is not counted in the arbitration.

Top module: `bus_arb_node`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bus_req_o and master_o are both low.
- R2: Across all nodes on a bus, at most one master_o is high in any cycle.
- R3: Line index k carries the request of level k+1, and a higher index means a higher priority. The node that wins is the highest-indexed asserted line, after lines excluded by R6 and the current master's line are removed.
- R4: A node that samples xfer_req_i high while idle raises bus_req_o in the next cycle. If it wins, it raises master_o in the cycle after that.
- R5: A node never holds master_o high in two adjacent cycles, and each grant lasts exactly one cycle.
- R6: In the cycle after its master cycle, a node is in backoff. In that cycle bus_req_o is high only if xfer_req_i was high at the end of the master cycle. Its line does not count toward winning, so a bus with no other request stays without a master in the next cycle.
- R7: Once raised, bus_req_o stays high until the node becomes master, whatever xfer_req_i does. After a grant with no new request, the node returns to idle with bus_req_o low.
- R8: A node's bus_req_o is low during its master cycle.
- R9: With levels 4, 3 and 2 requesting without pause, the bus rotates 4, 3, 2 and level 1 is starved. Level 1 is served once the higher requests stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | Local device wants one bus transaction |
| bus_req_i | input | N_DEV | All request lines on the bus, own line included, index = level-1 |
| bus_req_o | output | 1 | This node's request line |
| master_o | output | 1 | This node owns the bus this cycle |

## Verification
The bench builds four copies with N_DEV=4 and LVL set to 1, 2, 3 and 4, all wired to one shared request bus. This setup brings every priority comparison within reach, including the lowest level, which has no line below it. It also exercises the case where a backoff line is excluded while other lines are idle, which leaves the bus empty for a cycle. With three persistent higher levels, the bench reaches the three-way rotation that starves level 1 and reports it. It then shows level 1 being served once that pressure is removed.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_MST     = 3'd2,
    ST_BK_REQ  = 3'd3,
    ST_BK_IDLE = 3'd4
  } node_st_e;

endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] win_oh_o
);

  // highest index wins
  for (genvar k = 0; k < N; k++) begin : g_pick
    if (k == N-1) begin : g_top
      assign win_oh_o[k] = valid_i[k];
    end else begin : g_low
      assign win_oh_o[k] = valid_i[k] & ~(|valid_i[N-1:k+1]);
    end
  end

endmodule

// File: rtl/arb_history.sv
module arb_history #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] win_oh_i,
  output logic [N-1:0] cur_mst_o,
  output logic [N-1:0] excl_o
);

  logic [N-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= win_oh_i;
      prev_q <= cur_q;
    end
  end

  assign cur_mst_o = cur_q;
  // current master and the node in backoff do not compete
  assign excl_o    = cur_q | prev_q;

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_req_i,
  input  logic win_self_i,
  output logic bus_req_o,
  output logic master_o
);

  node_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (xfer_req_i) st_d = ST_REQ;
      ST_REQ:     if (win_self_i) st_d = ST_MST;
      ST_MST:     st_d = xfer_req_i ? ST_BK_REQ : ST_BK_IDLE;
      ST_BK_REQ:  st_d = ST_REQ;
      ST_BK_IDLE: st_d = xfer_req_i ? ST_REQ : ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign bus_req_o = (st_q == ST_REQ) || (st_q == ST_BK_REQ);
  assign master_o  = (st_q == ST_MST);

endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node #(
  parameter int N_DEV = 4,
  parameter int LVL   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_req_i,
  input  logic [N_DEV-1:0] bus_req_i,
  output logic             bus_req_o,
  output logic             master_o
);

  localparam int IDX = LVL - 1;

  logic [N_DEV-1:0] excl, valid, win_oh, cur_mst;
  logic             win_self;

  arb_history #(.N(N_DEV)) i_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_oh_i  (win_oh),
    .cur_mst_o (cur_mst),
    .excl_o    (excl)
  );

  assign valid = bus_req_i & ~excl;

  arb_pick #(.N(N_DEV)) i_pick (
    .valid_i  (valid),
    .win_oh_o (win_oh)
  );

  assign win_self = win_oh[IDX];

  arb_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xfer_req_i (xfer_req_i),
    .win_self_i (win_self),
    .bus_req_o  (bus_req_o),
    .master_o   (master_o)
  );

endmodule

// File: rtl/bus_arb_node_chk.sv
module bus_arb_node_chk #(
  parameter int N_DEV = 4,
  parameter int LVL   = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_req_o,
  input logic             master_o,
  input logic             win_self,
  input logic [N_DEV-1:0] cur_mst
);

  localparam int IDX = LVL - 1;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cur_mst));

  p_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |-> cur_mst[IDX]);

  p_win_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && win_self) |=> master_o);

  p_from_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |-> $past(bus_req_o));

  p_no_back2back_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |=> !master_o);

  p_bk_excluded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(master_o) |-> !win_self);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !win_self) |=> bus_req_o);

  p_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_o |-> !bus_req_o);

endmodule

bind bus_arb_node bus_arb_node_chk #(.N_DEV(N_DEV), .LVL(LVL)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_req_o (bus_req_o),
  .master_o  (master_o),
  .win_self  (win_self),
  .cur_mst   (cur_mst)
);

// File: tb/test_bus_arb_node.sv
module test_bus_arb_node;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] xfer = '0;
  wire  [3:0] br;
  wire  [3:0] mst;
  int         ntot = 0;
  int         nbad = 0;
  logic       mon_en = 1'b0;
  logic [3:0] mst_prev = '0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  for (genvar k = 0; k < 4; k++) begin : g_dev
    bus_arb_node #(.N_DEV(4), .LVL(k+1)) i_bus_arb_node (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .xfer_req_i (xfer[k]),
      .bus_req_i  (br),
      .bus_req_o  (br[k]),
      .master_o   (mst[k])
    );
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // per-cycle bus rules
  always @(negedge clk) begin
    if (mon_en) begin
      chk($onehot0(mst), "R2 one master", mst, 0);
      chk((mst & mst_prev) == 0, "R5 adjacent grant", mst & mst_prev, 0);
      chk((mst & br) == 0, "R8 master drops req", mst & br, 0);
    end
    mst_prev <= mst;
  end

  task automatic drain();
    xfer = '0;
    for (int i = 0; i < 20; i++) begin
      if (br == 0 && mst == 0) break;
      tick();
    end
    chk(br == 0 && mst == 0, "R7 drain", {br, mst}, 0);
    repeat (3) tick();
  endtask

  task automatic t_reset();
    chk(br == 0, "R1 req in reset", br, 0);
    chk(mst == 0, "R1 master in reset", mst, 0);
    rst_ni = 1'b1;
    tick();
    chk(br == 0, "R1 req after reset", br, 0);
    chk(mst == 0, "R1 master after reset", mst, 0);
    mon_en = 1'b1;
  endtask

  task automatic t_single();
    xfer = 4'b0001;
    tick();
    chk(br == 4'b0001, "R4 req raised", br, 4'b0001);
    chk(mst == 0, "R4 no grant yet", mst, 0);
    xfer = '0;
    tick();
    chk(mst == 4'b0001, "R4 grant", mst, 4'b0001);
    chk(br == 0, "R8 req low", br, 0);
    tick();
    chk(mst == 0 && br == 0, "R6 backoff idle", {br, mst}, 0);
    tick();
    chk(br == 0, "R7 idle after service", br, 0);
    drain();
  endtask

  task automatic t_all_once();
    logic [3:0] exp;
    xfer = 4'b1111;
    tick();
    chk(br == 4'b1111, "R4 all req", br, 4'b1111);
    xfer = '0;
    for (int i = 0; i < 5; i++) begin
      tick();
      exp = (i < 4) ? 4'(4'b1000 >> i) : 4'b0000;
      chk(mst == exp, "R3 priority order", mst, exp);
    end
    drain();
  endtask

  task automatic t_alternate();
    logic [3:0] exp;
    xfer = 4'b1001;
    tick();
    chk(mst == 0, "R4 both req", mst, 0);
    for (int i = 1; i <= 9; i++) begin
      tick();
      exp = (i % 3 == 1) ? 4'b1000 : (i % 3 == 2) ? 4'b0001 : 4'b0000;
      chk(mst == exp, "R6 backoff excluded", mst, exp);
      if (i % 3 == 2) chk(br[3] == 1'b1, "R6 backoff keeps req", br, 4'b1000);
    end
    drain();
  endtask

  task automatic t_alone();
    logic [3:0] exp;
    xfer = 4'b1000;
    tick();
    for (int i = 1; i <= 7; i++) begin
      tick();
      exp = (i % 3 == 1) ? 4'b1000 : 4'b0000;
      chk(mst == exp, "R6 lone requester", mst, exp);
      if (i % 3 != 1) chk(br == 4'b1000, "R7 req held", br, 4'b1000);
    end
    drain();
  endtask

  task automatic t_starve();
    logic [3:0] exp;
    int         n1 = 0;
    bit         got = 1'b0;
    xfer = 4'b1111;
    tick();
    for (int i = 1; i <= 30; i++) begin
      tick();
      exp = (i % 3 == 1) ? 4'b1000 : (i % 3 == 2) ? 4'b0100 : 4'b0010;
      chk(mst == exp, "R9 rotation", mst, exp);
      if (mst[0]) n1++;
    end
    chk(n1 == 0, "R9 level1 starved", n1, 0);
    chk(br[0] == 1'b1, "R9 level1 waiting", br, 1);
    if (n1 == 0) $display("note: starvation of level 1 detected under persistent 4/3/2");
    xfer = 4'b0001;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (mst[0]) begin
        got = 1'b1;
        break;
      end
    end
    chk(got, "R9 level1 served after release", got, 1);
    drain();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_single();
    t_all_once();
    t_alternate();
    t_alone();
    t_starve();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      ntot++;
      nbad++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

endmodule